// File: doc/BRIEF.md
# Prescaled Up-Counting Timer Base

This block is a timer base for general use. A programmable prescaler divides the incoming clock, and the main counter advances once per full prescaler period. The counter climbs from zero to a reload limit and then wraps to zero, which marks an overflow. A repetition down-counter sets how many overflows pass before an update event occurs. At an update event, the prescaler, reload and repetition settings are copied from their software-written staging registers into the working copies that control counting.

Software can change all three settings at any time through a single-beat write port. The new values stay staged until the next update event, so a running period is never cut short or stretched. A software trigger forces an update and restarts the count at once. A disable input stops overflow-driven updates, and the counter keeps running on the settings it already has.

Top module: `upcnt_timer`

## Requirements
- R1: In the cycle after synchronous reset, `count_o` is 0 and `ovf_o` and `upd_o` are low. All staged and working settings reset to 0, so with no writes an enabled counter stays at 0 and `ovf_o` is high on every enabled cycle.
- R2: While `cnt_en` is high, `count_o` advances by one after every (P+1) enabled clocks, where P is the working prescaler value. It counts 0, 1, … up to the working reload value L, and on the next count it returns to 0.
- R3: `ovf_o` is high for exactly the cycle in which `count_o` first shows 0 after a wrap from L. It is never raised by the software trigger.
- R4: With working repetition value N, an overflow-driven update (`upd_o` high together with `ovf_o`) occurs on every (N+1)-th overflow, and no update occurs on the other overflows.
- R5: A cycle with `swtrig` high makes the next cycle show `count_o`=0, `upd_o`=1 and `ovf_o`=0. It restarts the prescaler phase and the repetition count, and it loads all working settings from the staged values as they stood before any write in that same cycle. `upd_dis` does not block it.
- R6: While `upd_dis` is high, overflows still occur but do not produce updates. The working settings stay as they are, and the repetition count restarts from the working value N.
- R7: A write (`wr_en` high) sets one staged value, selected by `wr_sel`: 0 = prescaler (16 bits), 1 = reload limit (16 bits), 2 = repetition (`wr_data[7:0]`), 3 = nothing. A staged value affects counting only after the next update event.
- R8: While `cnt_en` is low and `swtrig` is low, `count_o` and the prescaler phase hold their values, and `ovf_o` and `upd_o` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Counting enable |
| wr_en | input | 1 | Write strobe for a staged setting |
| wr_sel | input | 2 | Staged register select (0 prescaler, 1 reload, 2 repetition, 3 none) |
| wr_data | input | 16 | Write data |
| swtrig | input | 1 | Software-forced update and restart |
| upd_dis | input | 1 | Blocks overflow-driven updates |
| count_o | output | 16 | Current counter value |
| ovf_o | output | 1 | Overflow pulse |
| upd_o | output | 1 | Update event pulse |

## Verification
The hardest case to reach from the ports is a write that lands on the same cycle as an update, either forced or overflow-driven. The working copy must take the older staged value, and the new write must wait for the following update. The bench reaches this case by several means: it issues triggers beside writes on purpose, it changes the prescaler during a multi-overflow repetition window, and it runs a long random phase with dense writes and small limits so that updates fall often. It also holds `upd_dis` across wraps so that the repetition count has to restart from its working value and not from the staged one.

// File: rtl/upcnt_pkg.sv
package upcnt_pkg;
  typedef enum logic [1:0] {
    SEL_PSC  = 2'd0,
    SEL_ARR  = 2'd1,
    SEL_REP  = 2'd2,
    SEL_NONE = 2'd3
  } wsel_e;
endpackage

// File: rtl/upcnt_regs.sv
module upcnt_regs
  import upcnt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int REP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  wsel_e            wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             load,
  output logic [CNT_W-1:0] psc_act,
  output logic [CNT_W-1:0] arr_act,
  output logic [REP_W-1:0] rep_act,
  output logic [REP_W-1:0] rep_pre
);
  logic [CNT_W-1:0] psc_pre;
  logic [CNT_W-1:0] arr_pre;

  // staging registers written by software
  always_ff @(posedge clk) begin
    if (rst) begin
      psc_pre <= '0;
      arr_pre <= '0;
      rep_pre <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_PSC: psc_pre <= wr_data;
        SEL_ARR: arr_pre <= wr_data;
        SEL_REP: rep_pre <= wr_data[REP_W-1:0];
        default: ;
      endcase
    end
  end

  // working copies: take staged values as they were before this cycle's write
  always_ff @(posedge clk) begin
    if (rst) begin
      psc_act <= '0;
      arr_act <= '0;
      rep_act <= '0;
    end else if (load) begin
      psc_act <= psc_pre;
      arr_act <= arr_pre;
      rep_act <= rep_pre;
    end
  end
endmodule

// File: rtl/upcnt_psc.sv
module upcnt_psc #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             clr,
  input  logic [CNT_W-1:0] psc_act,
  output logic             tick
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic [CNT_W-1:0] phase;

  assign tick = en && !clr && (phase >= psc_act);

  always_ff @(posedge clk) begin
    if (rst || clr)  phase <= '0;
    else if (tick)   phase <= '0;
    else if (en)     phase <= phase + ONE;
  end
endmodule

// File: rtl/upcnt_core.sv
module upcnt_core #(
  parameter int CNT_W = 16,
  parameter int REP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             swtrig,
  input  logic             upd_dis,
  input  logic [CNT_W-1:0] arr_act,
  input  logic [REP_W-1:0] rep_act,
  input  logic [REP_W-1:0] rep_pre,
  output logic             upd_evt,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf_q,
  output logic             upd_q
);
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);
  localparam logic [REP_W-1:0] ONE_R = REP_W'(1);

  logic [REP_W-1:0] rep_cnt;
  logic             wrap;
  logic             ovf_evt;
  logic             rep_zero;

  assign wrap     = tick && (cnt >= arr_act);
  assign ovf_evt  = wrap && !swtrig;
  assign rep_zero = (rep_cnt == '0);
  assign upd_evt  = swtrig || (ovf_evt && rep_zero && !upd_dis);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      rep_cnt <= '0;
      ovf_q   <= 1'b0;
      upd_q   <= 1'b0;
    end else begin
      ovf_q <= ovf_evt;
      upd_q <= upd_evt;
      if (swtrig) begin
        cnt     <= '0;
        rep_cnt <= rep_pre;
      end else if (tick) begin
        cnt <= wrap ? '0 : cnt + ONE_C;
        if (wrap) begin
          if (!rep_zero)    rep_cnt <= rep_cnt - ONE_R;
          else if (upd_dis) rep_cnt <= rep_act;
          else              rep_cnt <= rep_pre;
        end
      end
    end
  end
endmodule

// File: rtl/upcnt_timer.sv
module upcnt_timer #(
  parameter int CNT_W = 16,
  parameter int REP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             swtrig,
  input  logic             upd_dis,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o,
  output logic             upd_o
);
  logic [CNT_W-1:0] psc_act;
  logic [CNT_W-1:0] arr_act;
  logic [REP_W-1:0] rep_act;
  logic [REP_W-1:0] rep_pre;
  logic             tick;
  logic             upd_evt;

  upcnt_regs #(.CNT_W(CNT_W), .REP_W(REP_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en),
    .wr_sel(upcnt_pkg::wsel_e'(wr_sel)), .wr_data(wr_data),
    .load(upd_evt), .psc_act(psc_act), .arr_act(arr_act),
    .rep_act(rep_act), .rep_pre(rep_pre)
  );

  upcnt_psc #(.CNT_W(CNT_W)) psc_i (
    .clk(clk), .rst(rst), .en(cnt_en), .clr(swtrig),
    .psc_act(psc_act), .tick(tick)
  );

  upcnt_core #(.CNT_W(CNT_W), .REP_W(REP_W)) core_i (
    .clk(clk), .rst(rst), .tick(tick), .swtrig(swtrig), .upd_dis(upd_dis),
    .arr_act(arr_act), .rep_act(rep_act), .rep_pre(rep_pre),
    .upd_evt(upd_evt), .cnt(count_o), .ovf_q(ovf_o), .upd_q(upd_o)
  );
endmodule

// File: rtl/upcnt_timer_chk.sv
module upcnt_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cnt_en,
  input logic             swtrig,
  input logic             upd_dis,
  input logic [CNT_W-1:0] count_o,
  input logic             ovf_o,
  input logic             upd_o
);
  logic past_rst = 1'b1;
  always_ff @(posedge clk) past_rst <= rst;

  // R3: an overflow pulse always coincides with a zero count
  a_r3_ovf_at_zero: assert property (@(posedge clk) disable iff (rst || past_rst)
    ovf_o |-> (count_o == '0));

  // R2: the count only steps by one or wraps to zero
  a_r2_step: assert property (@(posedge clk) disable iff (rst || past_rst)
    (count_o != $past(count_o)) |-> ((count_o == $past(count_o) + CNT_W'(1)) || (count_o == '0)));

  // R5: a trigger gives update, zero count, no overflow
  a_r5_trigger: assert property (@(posedge clk) disable iff (rst || past_rst)
    $past(swtrig) |-> (upd_o && !ovf_o && (count_o == '0)));

  // R6: disabled updates only come from the trigger
  a_r6_no_update: assert property (@(posedge clk) disable iff (rst || past_rst)
    ($past(upd_dis) && !$past(swtrig)) |-> !upd_o);

  // R4: every update comes with an overflow or a trigger
  a_r4_update_src: assert property (@(posedge clk) disable iff (rst || past_rst)
    upd_o |-> (ovf_o || $past(swtrig)));

  // R8: disabled counter holds still
  a_r8_hold: assert property (@(posedge clk) disable iff (rst || past_rst)
    (!$past(cnt_en) && !$past(swtrig)) |-> ($stable(count_o) && !ovf_o && !upd_o));
endmodule

bind upcnt_timer upcnt_timer_chk #(.CNT_W(CNT_W)) chk_i (.*);

// File: tb/upcnt_timer_tb_top.sv
module upcnt_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cnt_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        swtrig = 1'b0;
  logic        upd_dis = 1'b0;
  logic [15:0] count_o;
  logic        ovf_o;
  logic        upd_o;

  always #10 clk = ~clk;

  upcnt_timer dut_i (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .swtrig(swtrig), .upd_dis(upd_dis),
    .count_o(count_o), .ovf_o(ovf_o), .upd_o(upd_o)
  );

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;
  bit seen_edge = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_cnt, m_ph, m_rep;
  int s_psc, s_arr, s_rep;
  int w_psc, w_arr, w_rep;
  bit m_ovf, m_upd;
  int o_psc, o_arr, o_rep;

  always @(posedge clk) begin
    cyc++;
    seen_edge = 1;
    if (rst) begin
      m_cnt = 0; m_ph = 0; m_rep = 0;
      s_psc = 0; s_arr = 0; s_rep = 0;
      w_psc = 0; w_arr = 0; w_rep = 0;
      m_ovf = 0; m_upd = 0;
    end else begin
      o_psc = s_psc; o_arr = s_arr; o_rep = s_rep;
      m_ovf = 0; m_upd = 0;
      if (swtrig) begin
        m_cnt = 0; m_ph = 0; m_rep = o_rep; m_upd = 1;
        w_psc = o_psc; w_arr = o_arr; w_rep = o_rep;
      end else if (cnt_en) begin
        if (m_ph >= w_psc) begin
          m_ph = 0;
          if (m_cnt >= w_arr) begin
            m_cnt = 0; m_ovf = 1;
            if (m_rep > 0) m_rep--;
            else if (upd_dis) m_rep = w_rep;
            else begin
              m_upd = 1; m_rep = o_rep;
              w_psc = o_psc; w_arr = o_arr; w_rep = o_rep;
            end
          end else m_cnt++;
        end else m_ph++;
      end
      if (wr_en) begin
        case (wr_sel)
          2'd0: s_psc = wr_data;
          2'd1: s_arr = wr_data;
          2'd2: s_rep = wr_data[7:0];
          default: ;
        endcase
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (seen_edge && !done) begin
      check(count_o == 16'(m_cnt), cur_req, "count", int'(count_o), m_cnt);
      check(ovf_o == m_ovf, cur_req, "ovf", int'(ovf_o), int'(m_ovf));
      check(upd_o == m_upd, cur_req, "upd", int'(upd_o), int'(m_upd));
    end
  end

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int sel, input int data);
    wr_en = 1; wr_sel = 2'(sel); wr_data = 16'(data);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic trig();
    swtrig = 1;
    @(negedge clk);
    swtrig = 0;
  endtask

  initial begin
    cycles(3);
    rst = 0;
    cycles(1);
    // R1: reset state
    check(count_o == 0 && !ovf_o && !upd_o, "R1", "reset state", int'(count_o), 0);
    cnt_en = 1;
    cycles(5);
    check(ovf_o == 1, "R1", "default overflow each cycle", int'(ovf_o), 1);

    // R7: staged writes do nothing until an update
    cur_req = "R7";
    wr(0, 2); wr(1, 5); wr(2, 1);
    cycles(4);
    check(count_o == 0, "R7", "staged values not yet active", int'(count_o), 0);

    // R5: forced update loads values and restarts
    cur_req = "R5";
    trig();
    check(upd_o && count_o == 0, "R5", "trigger result", int'(upd_o), 1);

    // R2, R3, R4: run with prescaler 2, limit 5, repetition 1
    cur_req = "R2";
    cycles(3);
    check(count_o == 1, "R2", "one step per three clocks", int'(count_o), 1);
    cur_req = "R4";
    cycles(60);

    // R7: prescaler change mid-window waits for the update
    cur_req = "R7";
    wr(0, 0);
    cycles(50);
    // write beside a trigger: trigger takes the older staged value
    wr_en = 1; wr_sel = 2'd1; wr_data = 16'd3; swtrig = 1;
    @(negedge clk);
    wr_en = 0; swtrig = 0;
    cycles(20);
    wr(3, 16'hFFFF);
    cycles(10);

    // R8: enable low holds state
    cur_req = "R8";
    cnt_en = 0;
    cycles(8);
    cnt_en = 1;
    cycles(3);
    cnt_en = 0;
    cycles(4);
    cnt_en = 1;

    // R6: updates disabled, overflows continue
    cur_req = "R6";
    wr(2, 2); wr(1, 2);
    upd_dis = 1;
    cycles(60);
    check(upd_o == 0, "R6", "no update while disabled", int'(upd_o), 0);
    trig();
    check(upd_o == 1, "R6", "trigger overrides disable", int'(upd_o), 1);
    cycles(30);
    upd_dis = 0;
    cycles(30);

    // random phase covering all requirements
    cur_req = "R4";
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      cnt_en = (r < 85);
      upd_dis = ($urandom_range(0, 9) == 0);
      swtrig = ($urandom_range(0, 59) == 0);
      wr_en = ($urandom_range(0, 7) == 0);
      wr_sel = 2'($urandom_range(0, 3));
      wr_data = 16'($urandom_range(0, 6));
      @(negedge clk);
    end
    swtrig = 0; wr_en = 0; upd_dis = 0;
    cycles(2);
    report();
  end
endmodule